// File: doc/BRIEF.md
# Functional unit pool allocator

This block sits beside the issue stage of an out-of-order core and hands out execution units from a small pool. Each unit offers a set of operation classes, fixed by parameters. For every class and unit, a parameter gives a result latency and a flag that says whether the unit is fully pipelined for that class. For each class the pool derives two values. The class latency is the largest latency among the units that offer the class. The class is pipelined only if every unit that offers it is pipelined for it.

An issue request carries an op class on a valid/ready handshake. `req_ready` is computed from the class and the pool state and never from `req_valid`. The requester may hold `req_valid` high and may change `req_class` while `req_ready` is low; no request is taken until both are high in the same cycle. In that cycle `grant_unit` names the granted unit. A refused request is not queued, so the requester retries in a later cycle. A pipelined op leaves its unit free for the next cycle. An unpipelined op keeps its unit busy until its result completes. The result is announced on `cpl_valid`/`cpl_unit`. That output has no back-pressure.

The completion path is one shared result slot per cycle. A request is therefore also refused when its completion cycle has already been claimed by an op in flight.

Top module: `fu_pool_alloc`

## Requirements
- R1: A synchronous active-high reset frees every unit and cancels every pending completion. In the first cycle after reset `cpl_valid` is 0 and `req_ready` is 1 for every class that some unit offers.
- R2: `req_ready` is 1 exactly when some unit offering `req_class` is free and the completion cycle of the request is unclaimed. `grant_unit` is then the lowest-indexed free unit offering the class. The default pool has class codes 0 to 3. Units 0 and 1 offer classes 0 and 1, unit 2 offers classes 2 and 3, and unit 3 offers classes 0 and 2.
- R3: A request accepted in cycle t produces `cpl_valid` in cycle t+L, where L is the class latency (the maximum over the offering units). Default latencies are 3 for class 0 (units 0 and 1 at 3, unit 3 at 2), 12 for class 1, 9 for class 2 and 33 for class 3.
- R4: For a pipelined class (class 0 by default), the granted unit can be granted again in cycle t+1.
- R5: A class is unpipelined when any unit offering it is unpipelined for it; by default this is classes 1, 2 and 3. Class 2 is unpipelined even though unit 3 is pipelined for it, because unit 2 is not. For such an op the granted unit is not granted in cycles t+1 to t+L-1. It can be granted again in cycle t+L, the cycle of its own completion pulse.
- R6: Each completion is a single-cycle pulse on `cpl_valid` with `cpl_unit` equal to the unit granted for that op. At most one completion appears per cycle.
- R7: A request whose completion cycle t+L already holds the completion of an accepted op is refused, even when a unit is free.
- R8: A cycle with `req_valid` low grants nothing and reserves nothing, whatever `req_class` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Issue request present |
| req_class | input | CLS_W | Op class of the request |
| req_ready | output | 1 | Request can be accepted this cycle |
| grant_unit | output | UNIT_W | Unit granted when valid and ready are both high |
| cpl_valid | output | 1 | One-cycle completion pulse |
| cpl_unit | output | UNIT_W | Unit whose op completes |

## Verification
A busy counter left loaded too long, or freed too early, shows up at once. In the very next cycle that asks for the class, `req_ready` or `grant_unit` is wrong, because requests on class 1 or class 2 spill to the next unit or are refused. A corrupted or shifted completion slot appears as a missing, early or late `cpl_valid` in the cycle the arithmetic predicts. It also appears sooner as a wrong `req_ready`, for any request whose completion would land on that slot. A wrong pool latency or pipelined flag is visible within L cycles, through the completion timing or through the re-grant cycle of the unit.

// File: rtl/fu_pool_pkg.sv
package fu_pool_pkg;

  localparam int LAT_W = 6;
  typedef logic [LAT_W-1:0] lat_t;

  localparam int DEF_UNITS   = 4;
  localparam int DEF_CLASSES = 4;

  // bit index = unit*DEF_CLASSES + class
  localparam logic [DEF_UNITS*DEF_CLASSES-1:0] DEF_CAP  = 16'b0101_1100_0011_0011;
  localparam logic [DEF_UNITS*DEF_CLASSES-1:0] DEF_PIPE = 16'b0101_0000_0001_0001;

  // field index = unit*DEF_CLASSES + class, LAT_W bits each
  localparam logic [DEF_UNITS*DEF_CLASSES*LAT_W-1:0] DEF_LAT = {
    6'd0,  6'd9, 6'd0,  6'd2,   // unit 3
    6'd33, 6'd9, 6'd0,  6'd0,   // unit 2
    6'd0,  6'd0, 6'd12, 6'd3,   // unit 1
    6'd0,  6'd0, 6'd12, 6'd3    // unit 0
  };

endpackage

// File: rtl/fu_class_table.sv
module fu_class_table
  import fu_pool_pkg::*;
#(
  parameter int NU    = 4,
  parameter int NC    = 4,
  parameter int CLS_W = 2,
  parameter logic [NU*NC-1:0]       CAP  = '0,
  parameter logic [NU*NC-1:0]       PIPE = '0,
  parameter logic [NU*NC*LAT_W-1:0] LAT  = '0
) (
  input  logic [CLS_W-1:0] cls,
  output logic [NU-1:0]    cap_vec,
  output lat_t             cls_lat,
  output logic             cls_pipe
);

  logic [NC*NU-1:0]    cap_flat;
  logic [NC*LAT_W-1:0] lat_flat;
  logic [NC-1:0]       pipe_flat;

  for (genvar c = 0; c < NC; c++) begin : g_cls
    lat_t            lat_c;
    logic            pipe_c;
    logic [NU-1:0]   cap_c;

    always_comb begin
      lat_c  = '0;
      pipe_c = 1'b1;
      cap_c  = '0;
      for (int u = 0; u < NU; u++) begin
        if (CAP[u*NC+c]) begin
          cap_c[u] = 1'b1;
          if (LAT[(u*NC+c)*LAT_W +: LAT_W] > lat_c)
            lat_c = LAT[(u*NC+c)*LAT_W +: LAT_W];
          if (!PIPE[u*NC+c])
            pipe_c = 1'b0;
        end
      end
    end

    assign cap_flat[c*NU +: NU]       = cap_c;
    assign lat_flat[c*LAT_W +: LAT_W] = lat_c;
    assign pipe_flat[c]               = pipe_c;
  end

  always_comb begin
    cap_vec  = '0;
    cls_lat  = '0;
    cls_pipe = 1'b1;
    for (int c = 0; c < NC; c++) begin
      if (int'(cls) == c) begin
        cap_vec  = cap_flat[c*NU +: NU];
        cls_lat  = lat_flat[c*LAT_W +: LAT_W];
        cls_pipe = pipe_flat[c];
      end
    end
  end

endmodule

// File: rtl/fu_pick_lowest.sv
module fu_pick_lowest #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     req_vec,
  output logic [N-1:0]     gnt_vec,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);

  always_comb begin
    gnt_vec = '0;
    gnt_idx = '0;
    any     = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req_vec[i] && !any) begin
        gnt_vec[i] = 1'b1;
        gnt_idx    = IDX_W'(i);
        any        = 1'b1;
      end
    end
  end

  // R2
  gnt_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt_vec));

  // R2
  gnt_present_chk: assert property (@(posedge clk) disable iff (rst)
    (|req_vec) |-> (|gnt_vec));

endmodule

// File: rtl/fu_unit_busy.sv
module fu_unit_busy
  import fu_pool_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic grant,
  input  logic pipe,
  input  lat_t lat,
  output logic busy
);

  lat_t cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (grant && !pipe)
      cnt_q <= (lat == '0) ? '0 : lat - 1'b1;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R2
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (rst)
    grant |-> !busy);

  // R4
  pipe_free_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && pipe) |=> !busy);

  // R5
  unpipe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (grant && !pipe && lat > 6'd1) |=> busy);

endmodule

// File: rtl/fu_cpl_wheel.sv
module fu_cpl_wheel
  import fu_pool_pkg::*;
#(
  parameter int DEPTH  = 33,
  parameter int UNIT_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  lat_t              wr_lat,
  input  logic [UNIT_W-1:0] wr_unit,
  output logic              slot_taken,
  output logic              cpl_valid,
  output logic [UNIT_W-1:0] cpl_unit
);

  logic [DEPTH-1:0]  v_q, v_d;
  logic [UNIT_W-1:0] u_q [DEPTH];
  logic [UNIT_W-1:0] u_d [DEPTH];

  // slot k holds an op completing k cycles from now
  always_comb begin
    slot_taken = 1'b0;
    for (int k = 1; k < DEPTH; k++)
      if (int'(wr_lat) == k)
        slot_taken = v_q[k];
  end

  always_comb begin
    v_d = {1'b0, v_q[DEPTH-1:1]};
    for (int k = 0; k < DEPTH-1; k++)
      u_d[k] = u_q[k+1];
    u_d[DEPTH-1] = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (wr_en && int'(wr_lat) == k+1) begin
        v_d[k] = 1'b1;
        u_d[k] = wr_unit;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_q <= '0;
      for (int k = 0; k < DEPTH; k++)
        u_q[k] <= '0;
    end else begin
      v_q <= v_d;
      for (int k = 0; k < DEPTH; k++)
        u_q[k] <= u_d[k];
    end
  end

  assign cpl_valid = v_q[0];
  assign cpl_unit  = u_q[0];

  // R3
  short_lat_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_lat == 6'd1) |=> (cpl_valid && cpl_unit == $past(wr_unit)));

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !cpl_valid);

endmodule

// File: rtl/fu_pool_alloc.sv
module fu_pool_alloc
  import fu_pool_pkg::*;
#(
  parameter int NUM_UNITS   = DEF_UNITS,
  parameter int NUM_CLASSES = DEF_CLASSES,
  parameter logic [NUM_UNITS*NUM_CLASSES-1:0]       CAP  = DEF_CAP,
  parameter logic [NUM_UNITS*NUM_CLASSES-1:0]       PIPE = DEF_PIPE,
  parameter logic [NUM_UNITS*NUM_CLASSES*LAT_W-1:0] LAT  = DEF_LAT,
  localparam int CLS_W  = (NUM_CLASSES > 1) ? $clog2(NUM_CLASSES) : 1,
  localparam int UNIT_W = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CLS_W-1:0]  req_class,
  output logic              req_ready,
  output logic [UNIT_W-1:0] grant_unit,
  output logic              cpl_valid,
  output logic [UNIT_W-1:0] cpl_unit
);

  function automatic int calc_max_lat();
    int m;
    m = 2;
    for (int u = 0; u < NUM_UNITS; u++)
      for (int c = 0; c < NUM_CLASSES; c++)
        if (CAP[u*NUM_CLASSES+c] &&
            int'(LAT[(u*NUM_CLASSES+c)*LAT_W +: LAT_W]) > m)
          m = int'(LAT[(u*NUM_CLASSES+c)*LAT_W +: LAT_W]);
    return m;
  endfunction

  localparam int WHEEL_DEPTH = calc_max_lat();

  logic [NUM_UNITS-1:0] cap_vec, busy_vec, free_vec, gnt_vec;
  logic [UNIT_W-1:0]    gnt_idx;
  logic                 any_free, slot_taken, cls_pipe, fire;
  lat_t                 cls_lat;

  fu_class_table #(
    .NU(NUM_UNITS), .NC(NUM_CLASSES), .CLS_W(CLS_W),
    .CAP(CAP), .PIPE(PIPE), .LAT(LAT)
  ) u_table (
    .cls(req_class), .cap_vec(cap_vec), .cls_lat(cls_lat), .cls_pipe(cls_pipe)
  );

  assign free_vec = cap_vec & ~busy_vec;

  fu_pick_lowest #(.N(NUM_UNITS), .IDX_W(UNIT_W)) u_pick (
    .clk(clk), .rst(rst), .req_vec(free_vec),
    .gnt_vec(gnt_vec), .gnt_idx(gnt_idx), .any(any_free)
  );

  assign req_ready  = any_free && !slot_taken;
  assign fire       = req_valid && req_ready;
  assign grant_unit = gnt_idx;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fu_unit_busy u_busy (
      .clk(clk), .rst(rst), .grant(fire && gnt_vec[u]),
      .pipe(cls_pipe), .lat(cls_lat), .busy(busy_vec[u])
    );
  end

  fu_cpl_wheel #(.DEPTH(WHEEL_DEPTH), .UNIT_W(UNIT_W)) u_wheel (
    .clk(clk), .rst(rst), .wr_en(fire), .wr_lat(cls_lat), .wr_unit(gnt_idx),
    .slot_taken(slot_taken), .cpl_valid(cpl_valid), .cpl_unit(cpl_unit)
  );

  // R8
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!req_valid && busy_vec == '0) |=> (busy_vec == '0));

endmodule

// File: tb/fu_pool_alloc_test.sv
module fu_pool_alloc_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_class = '0;
  logic       req_ready;
  logic [1:0] grant_unit;
  logic       cpl_valid;
  logic [1:0] cpl_unit;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;

  int busy_until [4];
  bit ring_v [64];
  int ring_u [64];

  always #2 clk = ~clk;

  fu_pool_alloc uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_class(req_class),
    .req_ready(req_ready), .grant_unit(grant_unit),
    .cpl_valid(cpl_valid), .cpl_unit(cpl_unit)
  );

  function automatic int clat(int c);
    case (c)
      0: return 3;
      1: return 12;
      2: return 9;
      default: return 33;
    endcase
  endfunction

  function automatic bit cpipe(int c);
    return c == 0;
  endfunction

  function automatic bit sup(int u, int c);
    case (u)
      0, 1: return c == 0 || c == 1;
      2: return c == 2 || c == 3;
      default: return c == 0 || c == 2;
    endcase
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int u = 0; u < 4; u++) busy_until[u] = 0;
    for (int k = 0; k < 64; k++) begin ring_v[k] = 0; ring_u[k] = 0; end
  endtask

  task automatic step(bit v, int c, string tag);
    int L, eu, slot;
    bit any_cap_free, unit_hold, exp_ready, ev;
    string rtag, ctag, utag;
    @(negedge clk);
    req_valid = v;
    req_class = 2'(c);
    #1;
    L = clat(c);
    eu = 0; any_cap_free = 0; unit_hold = 0;
    for (int u = 3; u >= 0; u--) begin
      if (sup(u, c)) begin
        if (busy_until[u] <= cyc) begin any_cap_free = 1; eu = u; end
        else unit_hold = 1;
      end
    end
    slot = (cyc + L) % 64;
    exp_ready = any_cap_free && !ring_v[slot];
    if (exp_ready) rtag = "R2";
    else if (!any_cap_free) rtag = unit_hold ? "R5" : "R2";
    else rtag = "R7";
    ctag = "R3"; utag = "R6";
    if (tag != "") begin rtag = tag; ctag = tag; utag = tag; end
    check(req_ready === exp_ready, rtag, int'(req_ready), int'(exp_ready));
    if (exp_ready)
      check(grant_unit === 2'(eu), rtag, int'(grant_unit), eu);
    ev = ring_v[cyc % 64];
    check(cpl_valid === ev, ctag, int'(cpl_valid), int'(ev));
    if (ev)
      check(cpl_unit === 2'(ring_u[cyc % 64]), utag, int'(cpl_unit), ring_u[cyc % 64]);
    ring_v[cyc % 64] = 0;
    @(posedge clk);
    if (v && exp_ready) begin
      ring_v[slot] = 1;
      ring_u[slot] = eu;
      busy_until[eu] = cpipe(c) ? cyc + 1 : cyc + L;
    end
    cyc++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (2) begin @(posedge clk); cyc++; end
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    for (int c = 0; c < 4; c++) begin
      req_class = 2'(c);
      #1;
      check(req_ready === 1'b1, "R1", int'(req_ready), 1);
      check(cpl_valid === 1'b0, "R1", int'(cpl_valid), 0);
    end
    @(posedge clk);
    cyc++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, tag);
  endtask

  initial begin
    model_reset();
    do_reset();

    // R4: class 0 back to back stays on unit 0
    for (int i = 0; i < 6; i++) step(1, 0, "R4");
    idle(36, "");

    // R3: class 0 spills to unit 3 but completes at the pool latency
    step(1, 1, "");
    step(1, 1, "");
    step(1, 0, "R3");
    idle(36, "");

    // R5: unpipelined units, retry until granted in the completion cycle
    step(1, 3, "");
    for (int i = 0; i < 36; i++) step(1, 3, "R5");
    idle(36, "");
    for (int i = 0; i < 4; i++) step(1, 2, "");
    idle(36, "");

    // R8: idle requests reserve nothing
    for (int i = 0; i < 20; i++) step(0, i % 4, "R8");
    for (int c = 0; c < 4; c++) step(0, c, "R8");

    // R1: reset cancels pending completions
    step(1, 3, "");
    step(1, 1, "");
    idle(3, "");
    do_reset();
    idle(40, "R1");

    // sweep of class pairs and gaps (covers R7 collisions)
    for (int c1 = 0; c1 < 4; c1++)
      for (int c2 = 0; c2 < 4; c2++)
        for (int g = 0; g <= clat(c1) + 1; g++) begin
          step(1, c1, "");
          idle(g, "");
          step(1, c2, "");
          step(1, c2, "");
          idle(35, "");
        end

    // random traffic
    for (int i = 0; i < 4000; i++)
      step(($urandom % 10) < 7, int'($urandom % 4), "");
    idle(36, "");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual %0d expected %0d", cyc, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule